// File: doc/BRIEF.md
# DRAM ECC Error Status and Log Capture

This block sits beside a memory controller's ECC decoders and records error events for up to two DRAM channels. In each cycle every channel presents an event: a correctable flag, an uncorrectable flag, and the column, row, bank, rank and 8-bit syndrome of the failing access. The block keeps a small summary status register with one bit for each error class, and a 64-bit log for each channel that holds the details of one error. An interrupt line is raised while any status bit is set.

Software reads the status and the logs through a simple register port and clears status bits by writing ones to them. When a write leaves the status at zero, the log valid flags are also cleared, so the logs can capture new errors. The logs keep the most severe information. An uncorrectable error replaces a held correctable entry. A correctable error never replaces an uncorrectable one. The first of several correctable errors is the one kept. A strap input puts the block in single-channel mode, in which the second channel is ignored.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the status register, both logs and `irq` are all zero.
- R2: The status register reads at offset 0x00. Bit 0 is the correctable-error flag and bit 1 is the uncorrectable-error flag. Bits 31:2 read zero, and so does any offset that maps to no register.
- R3: A status write clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: Channel c's log reads at offset 0x10+8c for bits 31:0 and at offset 0x14+8c for bits 63:32. The log holds column in 63:48, row in 47:32, bank in 31:29, rank in 28:27 and syndrome in 23:16. Bit 1 is the uncorrectable flag and bit 0 is the correctable flag. Bits 26:24 and 15:2 read zero. An accepted event shows in the registers one cycle after it is presented.
- R5: A correctable event on a channel whose log holds no entry is captured with only bit 0 set. A later correctable event leaves the log unchanged.
- R6: An uncorrectable event replaces a held correctable entry. The new entry has bit 1 set and bit 0 clear, and it sets status bit 1.
- R7: While a log holds an uncorrectable entry, further events of either class leave it unchanged. A correctable event still sets status bit 0.
- R8: A status write that leaves every status bit at zero clears bits 1:0 of every log. The other log fields keep their values, and the next event is captured again.
- R9: While `dual_ch_off` is 1, events on channel 1 change neither its log nor the status.
- R10: `irq` is the OR of the two status bits. It is still 1 during the cycle of the clearing write and is 0 from the next cycle on.
- R11: When an event and a clearing status write arrive in the same cycle, the event's status bit stays set and the event is captured after the re-arm.
- R12: An event that has both flags set is treated as uncorrectable only, and it does not set status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_ch_off | input | 1 | Strap: 1 selects single-channel mode |
| evt_ce | input | NUM_CH | Per-channel correctable-error event |
| evt_ue | input | NUM_CH | Per-channel uncorrectable-error event |
| evt_col | input | NUM_CH x 16 | Column of the failing access |
| evt_row | input | NUM_CH x 16 | Row of the failing access |
| evt_bank | input | NUM_CH x 3 | Bank of the failing access |
| evt_rank | input | NUM_CH x 2 | Rank of the failing access |
| evt_syn | input | NUM_CH x 8 | ECC syndrome |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Write data (write-one-to-clear mask for the status) |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| irq | output | 1 | Error interrupt |

## Verification
The main sequence drives channel 0 with a correctable error, then a second correctable error with different fields, then an uncorrectable error, then more errors of both classes. The log readouts show whether the block keeps the first correctable entry, lets the uncorrectable one replace it, and then refuses any further change. Status writes with zero, partial and full masks separate plain write-one-to-clear behaviour from the re-arm of the logs. An event placed in the same cycle as a clearing write shows whether the event takes priority. Further cases cover channel 1 with the strap off and on, an event with both flags set and all field bits at one (which also checks the reserved bits), and reads of offsets that map to no register.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYN_W  = 8;
  localparam int LOG_W  = 64;
  localparam int REG_W  = 32;
  localparam int ST_W   = 16;
  localparam int ST_CE  = 0;
  localparam int ST_UE  = 1;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYN_W-1:0]  syn;
    logic              ue;
    logic              ce;
  } chan_log_t;

  // Place the held fields at their fixed positions in the 64-bit word.
  function automatic logic [LOG_W-1:0] pack_log(chan_log_t l);
    return {l.col, l.row, l.bank, l.rank, 3'b000, l.syn, 14'd0, l.ue, l.ce};
  endfunction

  // A status write re-arms the logs when no set bit survives it.
  function automatic logic leaves_clear(logic [ST_W-1:0] st, logic [ST_W-1:0] mask);
    return (st & ~mask) == '0;
  endfunction
endpackage

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              evt_ce,
  input  logic              evt_ue,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] bank,
  input  logic [RANK_W-1:0] rank,
  input  logic [SYN_W-1:0]  syn,
  input  logic              rearm,
  output chan_log_t         log_q,
  output logic              hit_ce,
  output logic              hit_ue,
  output logic              cap_ce,
  output logic              cap_ue
);
  logic held_ue, held_ce;
  chan_log_t log_d;

  // An event with both flags is counted as uncorrectable only.
  assign hit_ue  = en & evt_ue;
  assign hit_ce  = en & evt_ce & ~evt_ue;
  // A re-arm in the same cycle frees the entry before the capture decision.
  assign held_ue = log_q.ue & ~rearm;
  assign held_ce = log_q.ce & ~rearm;
  assign cap_ue  = hit_ue & ~held_ue;
  assign cap_ce  = hit_ce & ~held_ue & ~held_ce;

  always_comb begin
    log_d = log_q;
    if (cap_ue || cap_ce) begin
      log_d.col  = col;
      log_d.row  = row;
      log_d.bank = bank;
      log_d.rank = rank;
      log_d.syn  = syn;
      log_d.ue   = cap_ue;
      log_d.ce   = cap_ce;
    end else if (rearm) begin
      log_d.ue = 1'b0;
      log_d.ce = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) log_q <= '0;
    else        log_q <= log_d;
  end
endmodule

// File: rtl/ecc_status_w1c.sv
module ecc_status_w1c
  import ecc_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [ST_W-1:0] wdata,
  input  logic            set_ce,
  input  logic            set_ue,
  output logic [ST_W-1:0] st_q,
  output logic            rearm
);
  logic [ST_W-1:0] clr_mask, set_mask, st_d;

  assign clr_mask = wr_hit ? wdata : '0;
  always_comb begin
    set_mask        = '0;
    set_mask[ST_CE] = set_ce;
    set_mask[ST_UE] = set_ue;
  end
  // Set has priority over clear for the same bit.
  assign st_d  = (st_q & ~clr_mask) | set_mask;
  assign rearm = wr_hit & leaves_clear(st_q, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
  import ecc_cap_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int STAT_OFS   = 'h00,
  parameter int LOG_BASE   = 'h10,
  parameter int LOG_STRIDE = 8
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [ST_W-1:0]               st,
  input  logic [NUM_CH-1:0][LOG_W-1:0]  words,
  output logic [REG_W-1:0]              rdata
);
  localparam int HALF = LOG_W / 2;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STAT_OFS)) rdata = {{(REG_W-ST_W){1'b0}}, st};
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(LOG_BASE + c * LOG_STRIDE))
        rdata = words[c][HALF-1:0];
      if (addr == ADDR_W'(LOG_BASE + c * LOG_STRIDE + 4))
        rdata = words[c][LOG_W-1:HALF];
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int LOG_BASE   = 'h10,
  parameter int LOG_STRIDE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dual_ch_off,
  input  logic [NUM_CH-1:0]             evt_ce,
  input  logic [NUM_CH-1:0]             evt_ue,
  input  logic [NUM_CH-1:0][COL_W-1:0]  evt_col,
  input  logic [NUM_CH-1:0][ROW_W-1:0]  evt_row,
  input  logic [NUM_CH-1:0][BANK_W-1:0] evt_bank,
  input  logic [NUM_CH-1:0][RANK_W-1:0] evt_rank,
  input  logic [NUM_CH-1:0][SYN_W-1:0]  evt_syn,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [ST_W-1:0]               reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  output logic                          irq
);
  localparam int STAT_OFS = 'h00;

  // Named internal events, brought out for the checker.
  logic [NUM_CH-1:0]            ch_en, hit_ce, hit_ue, cap_ce, cap_ue;
  logic [NUM_CH-1:0][LOG_W-1:0] log_words;
  logic [ST_W-1:0]              st_q;
  logic                         rearm;
  logic                         st_wr;

  assign st_wr = reg_wr & (reg_addr == ADDR_W'(STAT_OFS));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_log_t log_q;
    if (c == 0) begin : g_first
      assign ch_en[c] = 1'b1;
    end else begin : g_extra
      assign ch_en[c] = ~dual_ch_off;
    end
    ecc_chan_log u_log (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[c]),
      .evt_ce(evt_ce[c]),
      .evt_ue(evt_ue[c]),
      .col   (evt_col[c]),
      .row   (evt_row[c]),
      .bank  (evt_bank[c]),
      .rank  (evt_rank[c]),
      .syn   (evt_syn[c]),
      .rearm (rearm),
      .log_q (log_q),
      .hit_ce(hit_ce[c]),
      .hit_ue(hit_ue[c]),
      .cap_ce(cap_ce[c]),
      .cap_ue(cap_ue[c])
    );
    assign log_words[c] = pack_log(log_q);
  end

  ecc_status_w1c u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(st_wr),
    .wdata (reg_wdata),
    .set_ce(|hit_ce),
    .set_ue(|hit_ue),
    .st_q  (st_q),
    .rearm (rearm)
  );

  ecc_reg_read #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .STAT_OFS  (STAT_OFS),
    .LOG_BASE  (LOG_BASE),
    .LOG_STRIDE(LOG_STRIDE)
  ) u_read (
    .addr (reg_addr),
    .st   (st_q),
    .words(log_words),
    .rdata(reg_rdata)
  );

  assign irq = st_q[ST_UE] | st_q[ST_CE];
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk
  import ecc_cap_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         dual_ch_off,
  input logic [NUM_CH-1:0]            evt_ce,
  input logic [NUM_CH-1:0]            evt_ue,
  input logic                         reg_wr,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [ST_W-1:0]              reg_wdata,
  input logic                         irq,
  input logic [ST_W-1:0]              st_q,
  input logic                         rearm,
  input logic [NUM_CH-1:0][LOG_W-1:0] log_words
);
  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr && reg_addr == '0));

  // R6
  ue_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ue[0] |=> st_q[ST_UE]);

  // R11
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ce[0] && !evt_ue[0]) |=> st_q[ST_CE]);

  // R3
  zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && (reg_wdata & 16'h0003) == '0
     && evt_ce == '0 && evt_ue == '0) |=> $stable(st_q));

  // R7
  ue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_words[0][1] && !rearm) |=> $stable(log_words[0]));

  if (NUM_CH > 1) begin : g_two
    // R9
    single_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_ch_off && !rearm) |=> $stable(log_words[1]));
  end
endmodule

bind ecc_err_capture ecc_cap_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dual_ch_off(dual_ch_off),
  .evt_ce     (evt_ce),
  .evt_ue     (evt_ue),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq        (irq),
  .st_q       (st_q),
  .rearm      (rearm),
  .log_words  (log_words)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_ch_off = 1'b0;
  logic [NCH-1:0] evt_ce = '0, evt_ue = '0;
  logic [NCH-1:0][15:0] evt_col = '0, evt_row = '0;
  logic [NCH-1:0][2:0]  evt_bank = '0;
  logic [NCH-1:0][1:0]  evt_rank = '0;
  logic [NCH-1:0][7:0]  evt_syn = '0;
  logic reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #2 clk = ~clk;

  ecc_err_capture u_ecc_err_capture (
    .clk(clk), .rst_n(rst_n), .dual_ch_off(dual_ch_off),
    .evt_ce(evt_ce), .evt_ue(evt_ue), .evt_col(evt_col), .evt_row(evt_row),
    .evt_bank(evt_bank), .evt_rank(evt_rank), .evt_syn(evt_syn),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  logic rd_chk = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Expected low word, built arithmetically from the field positions.
  function automatic logic [31:0] lo_word(int bank, int rank, int syn, int ue, int ce);
    return 32'(bank * (2**29)) + 32'(rank * (2**27)) + 32'(syn * (2**16))
         + 32'(ue * 2) + 32'(ce);
  endfunction

  // Monitor: pops and compares in the middle of the cycle.
  always @(negedge clk) begin
    if (rd_chk && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      total++;
      if (reg_rdata !== cur.data || irq !== cur.irq) begin
        bad++;
        $display("FAIL %s addr=%02h rdata=%08h irq=%b expected rdata=%08h irq=%b",
                 cur.tag, cur.addr, reg_rdata, irq, cur.data, cur.irq);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input logic i, input string t);
    exp_t e;
    @(posedge clk); #1;
    reg_addr = a; rd_chk = 1'b1;
    e.addr = a; e.data = d; e.irq = i; e.tag = t;
    exp_q.push_back(e);
    @(posedge clk); #1;
    rd_chk = 1'b0;
  endtask

  // One cycle carrying an optional event and an optional status write.
  // During that cycle the status is read and checked against its old value.
  task automatic step(input int ch, input bit ue, input bit ce,
                      input logic [15:0] col, input logic [15:0] row,
                      input logic [2:0] bank, input logic [1:0] rank, input logic [7:0] syn,
                      input bit wr, input logic [15:0] wd,
                      input logic [31:0] old_st, input string t);
    exp_t e;
    @(posedge clk); #1;
    evt_ue[ch] = ue; evt_ce[ch] = ce;
    evt_col[ch] = col; evt_row[ch] = row; evt_bank[ch] = bank;
    evt_rank[ch] = rank; evt_syn[ch] = syn;
    reg_wr = wr; reg_wdata = wd; reg_addr = 8'h00;
    if (wr) begin
      rd_chk = 1'b1;
      e.addr = 8'h00; e.data = old_st; e.irq = (old_st[1:0] != 0); e.tag = t;
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    evt_ue = '0; evt_ce = '0; reg_wr = 1'b0; rd_chk = 1'b0;
  endtask

  task automatic ev(input int ch, input bit ue, input bit ce,
                    input logic [15:0] col, input logic [15:0] row,
                    input logic [2:0] bank, input logic [1:0] rank, input logic [7:0] syn);
    step(ch, ue, ce, col, row, bank, rank, syn, 1'b0, 16'h0, 32'h0, "");
  endtask

  task automatic wr_st(input logic [15:0] wd, input logic [31:0] old_st, input string t);
    step(0, 1'b0, 1'b0, 16'h0, 16'h0, 3'd0, 2'd0, 8'h0, 1'b1, wd, old_st, t);
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, 1'b0, "R1 status");
    rd(8'h10, 32'h0, 1'b0, "R1 log0 lo");
    rd(8'h1C, 32'h0, 1'b0, "R1 log1 hi");

    // R5/R4 first correctable error captured
    ev(0, 0, 1, 16'h1234, 16'h5678, 3'd5, 2'd2, 8'hA5);
    rd(8'h00, 32'h1, 1'b1, "R2 ce status");
    rd(8'h10, lo_word(5, 2, 'hA5, 0, 1), 1'b1, "R4 log0 lo ce");
    rd(8'h14, 32'h12345678, 1'b1, "R4 log0 hi ce");

    // R5 second correctable error keeps the first
    ev(0, 0, 1, 16'h1111, 16'h2222, 3'd1, 2'd1, 8'h3C);
    rd(8'h10, lo_word(5, 2, 'hA5, 0, 1), 1'b1, "R5 lo kept");
    rd(8'h14, 32'h12345678, 1'b1, "R5 hi kept");

    // R6 uncorrectable replaces correctable
    ev(0, 1, 0, 16'hBEEF, 16'h0042, 3'd7, 2'd3, 8'h81);
    rd(8'h00, 32'h3, 1'b1, "R6 status");
    rd(8'h10, lo_word(7, 3, 'h81, 1, 0), 1'b1, "R6 lo ue");
    rd(8'h14, 32'hBEEF0042, 1'b1, "R6 hi ue");

    // R3 partial clear
    wr_st(16'h0001, 32'h3, "R3 pre-write");
    rd(8'h00, 32'h2, 1'b1, "R3 partial clear");
    rd(8'h10, lo_word(7, 3, 'h81, 1, 0), 1'b1, "R8 no rearm on partial");

    // R7 further events cannot touch an uncorrectable entry
    ev(0, 0, 1, 16'h0101, 16'h0202, 3'd1, 2'd0, 8'h07);
    rd(8'h00, 32'h3, 1'b1, "R7 ce status still set");
    ev(0, 1, 0, 16'h0303, 16'h0404, 3'd2, 2'd1, 8'h09);
    rd(8'h10, lo_word(7, 3, 'h81, 1, 0), 1'b1, "R7 lo held");
    rd(8'h14, 32'hBEEF0042, 1'b1, "R7 hi held");

    // R3 zero write has no effect
    wr_st(16'h0000, 32'h3, "R3 pre-zero");
    rd(8'h00, 32'h3, 1'b1, "R3 zero write");

    // R10/R8 full clear, irq drops next cycle, flags re-armed
    wr_st(16'h0003, 32'h3, "R10 irq still high in write cycle");
    rd(8'h00, 32'h0, 1'b0, "R10 irq low after clear");
    rd(8'h10, lo_word(7, 3, 'h81, 0, 0), 1'b0, "R8 flags cleared");
    rd(8'h14, 32'hBEEF0042, 1'b0, "R8 fields retained");
    ev(0, 0, 1, 16'h0F0F, 16'hF0F0, 3'd2, 2'd0, 8'h11);
    rd(8'h10, lo_word(2, 0, 'h11, 0, 1), 1'b1, "R8 capture after rearm");

    // R11 event and clearing write in the same cycle
    step(0, 0, 1, 16'h7777, 16'h8888, 3'd3, 2'd1, 8'h5A, 1'b1, 16'h0001, 32'h1, "R11 pre");
    rd(8'h00, 32'h1, 1'b1, "R11 event wins");
    rd(8'h10, lo_word(3, 1, 'h5A, 0, 1), 1'b1, "R11 captured after rearm");
    rd(8'h14, 32'h77778888, 1'b1, "R11 hi");
    wr_st(16'h0001, 32'h1, "R3 pre");
    rd(8'h00, 32'h0, 1'b0, "R3 cleared");

    // Channel 1 in dual mode
    ev(1, 1, 0, 16'hABCD, 16'h1357, 3'd6, 2'd2, 8'hC3);
    rd(8'h00, 32'h2, 1'b1, "R4 ch1 status");
    rd(8'h18, lo_word(6, 2, 'hC3, 1, 0), 1'b1, "R4 log1 lo");
    rd(8'h1C, 32'hABCD1357, 1'b1, "R4 log1 hi");
    wr_st(16'h0002, 32'h2, "R8 pre");

    // R9 single-channel strap
    @(posedge clk); #1 dual_ch_off = 1'b1;
    ev(1, 0, 1, 16'h4444, 16'h5555, 3'd4, 2'd1, 8'h66);
    rd(8'h00, 32'h0, 1'b0, "R9 status untouched");
    rd(8'h18, lo_word(6, 2, 'hC3, 0, 0), 1'b0, "R9 log1 lo untouched");
    rd(8'h1C, 32'hABCD1357, 1'b0, "R9 log1 hi untouched");
    @(posedge clk); #1 dual_ch_off = 1'b0;

    // R12 both flags, all-ones fields, reserved bits zero
    ev(0, 1, 1, 16'hFFFF, 16'hFFFF, 3'd7, 2'd3, 8'hFF);
    rd(8'h00, 32'h2, 1'b1, "R12 ue only");
    rd(8'h10, 32'hF8FF0002, 1'b1, "R4 reserved zero");
    rd(8'h14, 32'hFFFFFFFF, 1'b1, "R4 hi all ones");

    // R2 unmapped offsets
    rd(8'h04, 32'h0, 1'b1, "R2 unmapped 04");
    rd(8'h08, 32'h0, 1'b1, "R2 unmapped 08");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule